// File: doc/BRIEF.md
# Flash Command Decoder

This block sits between a host write port and the write sequencer of a boot-block flash memory. It turns single bus write cycles into operation requests. Program and block erase each need two cycles. Suspend and resume each need one. The block also selects whether reads return array data or the status word. The block keeps its own state, and that state decides which commands it accepts. While a program is running, while an erase is running, while an erase is suspended, or after a cancelled program setup, only a small set of command codes does anything. Every other write is dropped without a trace.

Each write is a one-cycle strobe carrying an address and a data field. A mode input selects byte-wide or word-wide data. Command codes always come from the low byte. The sequencer reports back through a busy flag and a suspended flag. The decoder waits until busy has been seen high and then low before it treats an operation as finished. Out of the decoder come one-cycle request pulses, the latched program address and data, the latched erase block index, a read-mode select and an erase-sequence error flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_status is 0 (array reads), seq_err is 0 and no request pulse is issued.
- R2: In the idle state, a write of code FFh selects array reads (rd_status=0), and a write of code 70h selects status reads (rd_status=1).
- R3: Both 40h and 10h are program setup codes, and each sets rd_status=1. The next write issues one prog_start pulse and latches its address into prog_addr and its data into prog_data. In byte mode, only the low 8 bits of that data are kept and the rest is zero-filled.
- R4: A second program cycle whose data is all ones starts no program. The all-ones test covers the low 8 bits in byte mode and all 16 bits in word mode. After such a cycle, the decoder accepts only 70h until seq_busy is low, and rd_status stays 1. In word mode, 00FFh is ordinary data and starts a program.
- R5: While a program is running, every command other than 70h is ignored. The decoder goes back to idle once seq_busy has been high and then drops low.
- R6: Code 20h followed by D0h issues one erase_start pulse. erase_blk takes the value of the confirm-cycle address shifted right by BLK_BITS, so any address inside a block selects that block.
- R7: If the cycle after 20h carries any code other than D0h, no erase starts, seq_err goes to 1 and rd_status is 1. seq_err returns to 0 on the next program or erase setup.
- R8: While an erase is running, only 70h and B0h are accepted. B0h issues one susp_req pulse, and all other codes, D0h and FFh among them, are ignored.
- R9: While seq_susp is high after a suspend request, only FFh, 70h and D0h are accepted. D0h issues one resume_req pulse, and program and erase setup codes are ignored.
- R10: Command decoding uses only the low 8 bits of the data field. In word mode, the upper byte has no effect on which command is taken.
- R11: prog_start, erase_start, susp_req and resume_req each last exactly one cycle, and no two of them are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the command code sits in bits 7:0 |
| word_mode | input | 1 | 1 = word-wide data, 0 = byte-wide data |
| seq_busy | input | 1 | Write sequencer is running an operation |
| seq_susp | input | 1 | Write sequencer has reached the suspended state |
| prog_start | output | 1 | Program request pulse |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | DATA_W | Latched program data |
| erase_start | output | 1 | Block erase request pulse |
| erase_blk | output | ADDR_W-BLK_BITS | Latched erase block index |
| susp_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| rd_status | output | 1 | 1 = reads return status, 0 = reads return array data |
| seq_err | output | 1 | Erase setup was followed by a wrong code |

## Verification
The bench sends all-ones as the second program cycle in both data widths. A decoder that tested the full word in byte mode would start a program with data 00FF. One that tested only the low byte in word mode would drop a valid program. The bench also sends illegal commands, including D0h, 20h, 40h and FFh, while a program runs, while an erase runs and while an erase is suspended. It then shows through rd_status and the pulse counters that nothing moved. A decoder with loose gating would emit a stray erase or program pulse, or would flip the read mode. The bench gives setup and confirm cycles different addresses, so a design that latched the block address at setup would report the wrong block.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PSETUP,
    S_ESETUP,
    S_PRUN,
    S_ERUN,
    S_SWAIT,
    S_SUSP,
    S_ABORT
  } fcd_state_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_RD_ARRAY,
    K_RD_STAT,
    K_PROG,
    K_ERASE,
    K_CONFIRM,
    K_SUSPEND,
    K_OTHER
  } fcd_cmd_e;

  localparam int unsigned CODE_W = 8;

  localparam logic [CODE_W-1:0] CODE_RD_ARRAY = 8'hFF;
  localparam logic [CODE_W-1:0] CODE_RD_STAT  = 8'h70;
  localparam logic [CODE_W-1:0] CODE_PROG     = 8'h40;
  localparam logic [CODE_W-1:0] CODE_PROG_ALT = 8'h10;
  localparam logic [CODE_W-1:0] CODE_ERASE    = 8'h20;
  localparam logic [CODE_W-1:0] CODE_CONFIRM  = 8'hD0;
  localparam logic [CODE_W-1:0] CODE_SUSPEND  = 8'hB0;

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              stb,
  input  logic [DATA_W-1:0] data,
  input  logic              word_mode,
  output fcd_cmd_e          cmd,
  output logic              all_ones,
  output logic [DATA_W-1:0] pdata
);

  localparam int unsigned PAD_W = DATA_W - CODE_W;

  logic [CODE_W-1:0] code;

  assign code = data[CODE_W-1:0];

  // command classes come from the low byte only (R10)
  always_comb begin
    cmd = K_NONE;
    if (stb) begin
      case (code)
        CODE_RD_ARRAY:            cmd = K_RD_ARRAY;
        CODE_RD_STAT:             cmd = K_RD_STAT;
        CODE_PROG, CODE_PROG_ALT: cmd = K_PROG;
        CODE_ERASE:               cmd = K_ERASE;
        CODE_CONFIRM:             cmd = K_CONFIRM;
        CODE_SUSPEND:             cmd = K_SUSPEND;
        default:                  cmd = K_OTHER;
      endcase
    end
  end

  // the width of the all-ones test follows the bus mode (R4)
  assign all_ones = word_mode ? (&data) : (&code);

  generate
    if (PAD_W > 0) begin : g_pad
      assign pdata = word_mode ? data : {{PAD_W{1'b0}}, code};
    end else begin : g_nopad
      assign pdata = data;
    end
  endgenerate

endmodule

// File: rtl/fcd_block_map.sv
module fcd_block_map #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned BLK_BITS = 12
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic [ADDR_W-BLK_BITS-1:0] blk
);

  localparam int unsigned BLK_W = ADDR_W - BLK_BITS;

  // every offset inside a block maps to the same index (R6)
  assign blk = addr[ADDR_W-1 -: BLK_W];

endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BLK_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcd_cmd_e          cmd,
  input  logic              all_ones,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] pdata,
  input  logic [BLK_W-1:0]  blk_idx,
  input  logic              seq_busy,
  input  logic              seq_susp,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_start,
  output logic [BLK_W-1:0]  erase_blk,
  output logic              susp_req,
  output logic              resume_req,
  output logic              rd_status,
  output logic              seq_err
);

  fcd_state_e st, st_n;
  logic seen, seen_n;
  logic rd_n, err_n;
  logic pstart_n, estart_n, sreq_n, rreq_n;
  logic cap_prog, cap_erase;
  logic done;

  // the sequencer counts as finished only after busy was seen high
  assign done = seen && !seq_busy;

  always_comb begin
    st_n      = st;
    rd_n      = rd_status;
    err_n     = seq_err;
    seen_n    = seen | seq_busy;
    pstart_n  = 1'b0;
    estart_n  = 1'b0;
    sreq_n    = 1'b0;
    rreq_n    = 1'b0;
    cap_prog  = 1'b0;
    cap_erase = 1'b0;
    case (st)
      S_IDLE: begin
        case (cmd)
          K_RD_ARRAY: rd_n = 1'b0;
          K_RD_STAT:  rd_n = 1'b1;
          K_PROG: begin
            st_n  = S_PSETUP;
            rd_n  = 1'b1;
            err_n = 1'b0;
          end
          K_ERASE: begin
            st_n  = S_ESETUP;
            rd_n  = 1'b1;
            err_n = 1'b0;
          end
          default: ;
        endcase
      end
      S_PSETUP: begin
        if (cmd != K_NONE) begin
          if (all_ones) begin
            st_n = S_ABORT;
          end else begin
            st_n     = S_PRUN;
            pstart_n = 1'b1;
            cap_prog = 1'b1;
            seen_n   = 1'b0;
          end
        end
      end
      S_ESETUP: begin
        if (cmd == K_CONFIRM) begin
          st_n      = S_ERUN;
          estart_n  = 1'b1;
          cap_erase = 1'b1;
          seen_n    = 1'b0;
        end else if (cmd != K_NONE) begin
          st_n  = S_IDLE;
          err_n = 1'b1;
        end
      end
      S_PRUN: begin
        if (done) st_n = S_IDLE;
      end
      S_ERUN: begin
        if (cmd == K_SUSPEND) begin
          st_n   = S_SWAIT;
          sreq_n = 1'b1;
        end else if (done) begin
          st_n = S_IDLE;
        end
      end
      S_SWAIT: begin
        if (seq_susp)  st_n = S_SUSP;
        else if (done) st_n = S_IDLE;
      end
      S_SUSP: begin
        case (cmd)
          K_RD_ARRAY: rd_n = 1'b0;
          K_RD_STAT:  rd_n = 1'b1;
          K_CONFIRM: begin
            st_n   = S_ERUN;
            rd_n   = 1'b1;
            rreq_n = 1'b1;
            seen_n = 1'b0;
          end
          default: ;
        endcase
      end
      S_ABORT: begin
        if (!seq_busy) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      seen        <= 1'b0;
      rd_status   <= 1'b0;
      seq_err     <= 1'b0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      susp_req    <= 1'b0;
      resume_req  <= 1'b0;
    end else begin
      st          <= st_n;
      seen        <= seen_n;
      rd_status   <= rd_n;
      seq_err     <= err_n;
      prog_start  <= pstart_n;
      erase_start <= estart_n;
      susp_req    <= sreq_n;
      resume_req  <= rreq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (cap_prog) begin
      prog_addr <= addr;
      prog_data <= pdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_blk <= '0;
    end else if (cap_erase) begin
      erase_blk <= blk_idx;
    end
  end

  assert_pulse_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start || susp_req || resume_req) |=>
      !($past(prog_start) && prog_start) && !($past(erase_start) && erase_start) &&
      !($past(susp_req) && susp_req) && !($past(resume_req) && resume_req));

  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start, susp_req, resume_req}));

  assert_abort_noprog_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PSETUP && cmd != K_NONE && all_ones) |=> (!prog_start && st == S_ABORT));

  assert_prun_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRUN) |=> (st == S_PRUN || st == S_IDLE) && !erase_start && !susp_req);

  assert_erase_blk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> erase_blk == $past(blk_idx));

  assert_err_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> ($past(st) == S_ESETUP && !erase_start));

  assert_susp_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP) |=> (!prog_start && !erase_start && !susp_req));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned BLK_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       word_mode,
  input  logic                       seq_busy,
  input  logic                       seq_susp,
  output logic                       prog_start,
  output logic [ADDR_W-1:0]          prog_addr,
  output logic [DATA_W-1:0]          prog_data,
  output logic                       erase_start,
  output logic [ADDR_W-BLK_BITS-1:0] erase_blk,
  output logic                       susp_req,
  output logic                       resume_req,
  output logic                       rd_status,
  output logic                       seq_err
);

  localparam int unsigned BLK_W = ADDR_W - BLK_BITS;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  fcd_cmd_e          cmd;
  logic              all_ones;
  logic [DATA_W-1:0] pdata;
  logic [BLK_W-1:0]  blk_idx;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  assign rst_int_n = rst_sync[1];

  fcd_classify #(.DATA_W(DATA_W)) u_classify (
    .stb       (wr_stb),
    .data      (wr_data),
    .word_mode (word_mode),
    .cmd       (cmd),
    .all_ones  (all_ones),
    .pdata     (pdata)
  );

  fcd_block_map #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_blkmap (
    .addr (wr_addr),
    .blk  (blk_idx)
  );

  fcd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd         (cmd),
    .all_ones    (all_ones),
    .addr        (wr_addr),
    .pdata       (pdata),
    .blk_idx     (blk_idx),
    .seq_busy    (seq_busy),
    .seq_susp    (seq_susp),
    .prog_start  (prog_start),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .erase_start (erase_start),
    .erase_blk   (erase_blk),
    .susp_req    (susp_req),
    .resume_req  (resume_req),
    .rd_status   (rd_status),
    .seq_err     (seq_err)
  );

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int CLK_NS   = 10;
  localparam int ADDR_W   = 18;
  localparam int DATA_W   = 16;
  localparam int BLK_BITS = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic word_mode, seq_busy, seq_susp;
  logic prog_start, erase_start, susp_req, resume_req, rd_status, seq_err;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic [ADDR_W-BLK_BITS-1:0] erase_blk;

  int total = 0;
  int bad = 0;
  int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0, n_overlap = 0;
  int e_prog = 0, e_erase = 0, e_susp = 0, e_res = 0;
  logic done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BITS(BLK_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_mode(word_mode), .seq_busy(seq_busy), .seq_susp(seq_susp),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_blk(erase_blk), .susp_req(susp_req),
    .resume_req(resume_req), .rd_status(rd_status), .seq_err(seq_err)
  );

  logic [3:0] pl_prev;
  always @(posedge clk) begin
    if (prog_start)  n_prog++;
    if (erase_start) n_erase++;
    if (susp_req)    n_susp++;
    if (resume_req)  n_res++;
    if ($countones({prog_start, erase_start, susp_req, resume_req}) > 1) n_overlap++;
    if ((pl_prev & {prog_start, erase_start, susp_req, resume_req}) != 4'b0) n_overlap++;
    pl_prev <= {prog_start, erase_start, susp_req, resume_req};
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_counts(input string req);
    check({req, " prog pulses"}, n_prog, e_prog);
    check({req, " erase pulses"}, n_erase, e_erase);
    check({req, " suspend pulses"}, n_susp, e_susp);
    check({req, " resume pulses"}, n_res, e_res);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic seq_run();
    seq_busy = 1'b1;
    repeat (3) @(negedge clk);
    seq_busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    pl_prev = 4'b0;
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    word_mode = 1'b0; seq_busy = 1'b0; seq_susp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rd_status", rd_status, 0);
    check("R1 seq_err", seq_err, 0);
    check_counts("R1");
  endtask

  task automatic t_read_modes();
    word_mode = 1'b0;
    wr(0, 16'h0070); check("R2 status select", rd_status, 1);
    wr(0, 16'h00FF); check("R2 array select", rd_status, 0);
    word_mode = 1'b1;
    wr(0, 16'hAB70); check("R10 upper byte ignored status", rd_status, 1);
    wr(0, 16'h12FF); check("R10 upper byte ignored array", rd_status, 0);
    wr(0, 16'h0155); check("R2 unknown code ignored", rd_status, 0);
    check_counts("R2");
  endtask

  task automatic t_program();
    word_mode = 1'b0;
    wr(0, 16'h0040); check("R3 setup status mode", rd_status, 1);
    wr(18'h00123, 16'hAB5A); e_prog++;
    check_counts("R3 byte");
    check("R3 byte addr", prog_addr, 18'h00123);
    check("R3 byte data zero-fill", prog_data, 16'h005A);
    seq_run();
    word_mode = 1'b1;
    wr(0, 16'h7710); wr(18'h3FFFF, 16'h1234); e_prog++;
    check_counts("R3 alt word");
    check("R3 word addr", prog_addr, 18'h3FFFF);
    check("R3 word data", prog_data, 16'h1234);
    seq_run();
    wr(0, 16'h00FF); check("R3 back to idle", rd_status, 0);
  endtask

  task automatic t_abort();
    word_mode = 1'b0;
    seq_busy = 1'b1;
    wr(0, 16'h0040); wr(18'h00010, 16'h12FF);
    check_counts("R4 byte abort");
    check("R4 abort status mode", rd_status, 1);
    wr(0, 16'h00FF); check("R4 FF ignored in abort", rd_status, 1);
    wr(0, 16'h0020); wr(0, 16'h00D0);
    check_counts("R4 erase codes ignored");
    seq_busy = 1'b0;
    repeat (2) @(negedge clk);
    wr(0, 16'h00D0);
    check_counts("R4 stray confirm idle");
    wr(0, 16'h00FF); check("R4 released to idle", rd_status, 0);
    word_mode = 1'b1;
    wr(0, 16'h0040); wr(18'h00020, 16'h00FF); e_prog++;
    check_counts("R4 word 00FF is data");
    check("R4 word 00FF data", prog_data, 16'h00FF);
    seq_run();
    wr(0, 16'h0040); wr(18'h00020, 16'hFFFF);
    check_counts("R4 word FFFF abort");
    repeat (2) @(negedge clk);
    wr(0, 16'h00FF); check("R4 word abort released", rd_status, 0);
  endtask

  task automatic t_prog_gate();
    word_mode = 1'b1;
    wr(0, 16'h0040); wr(18'h00444, 16'h0F0F); e_prog++;
    seq_busy = 1'b1;
    wr(0, 16'h00FF); check("R5 FF ignored while programming", rd_status, 1);
    wr(0, 16'h0020); wr(18'h01000, 16'h00D0);
    wr(0, 16'h0040); wr(18'h00555, 16'h3333);
    check_counts("R5 gated");
    check("R5 prog addr unchanged", prog_addr, 18'h00444);
    seq_busy = 1'b0;
    repeat (2) @(negedge clk);
    wr(0, 16'h00FF); check("R5 idle after done", rd_status, 0);
  endtask

  task automatic t_erase();
    word_mode = 1'b0;
    wr(18'h01000, 16'h0020); wr(18'h2ABCD, 16'h00D0); e_erase++;
    check_counts("R6 erase");
    check("R6 block index", erase_blk, 6'h2A);
    check("R6 status mode", rd_status, 1);
    seq_run();
    wr(18'h05FFF, 16'h0020); wr(18'h05000, 16'h00D0); e_erase++;
    check("R6 block low offset", erase_blk, 6'h05);
    seq_run();
    wr(0, 16'h00FF); check("R6 back to idle", rd_status, 0);
  endtask

  task automatic t_erase_bad();
    wr(0, 16'h0020); wr(0, 16'h0070);
    check("R7 error flag", seq_err, 1);
    check("R7 status mode", rd_status, 1);
    check_counts("R7 no erase");
    wr(0, 16'h00D0);
    check_counts("R7 confirm after cancel ignored");
    wr(0, 16'h0020); check("R7 error cleared by setup", seq_err, 0);
    wr(0, 16'h0050); check("R7 error again", seq_err, 1);
    wr(0, 16'h0040); check("R7 cleared by program setup", seq_err, 0);
    wr(0, 16'hFFFF);
    wr(0, 16'h00FF); check("R7 idle", rd_status, 0);
  endtask

  task automatic t_suspend();
    word_mode = 1'b1;
    wr(18'h03000, 16'h0020); wr(18'h03000, 16'h00D0); e_erase++;
    seq_busy = 1'b1;
    wr(0, 16'h00FF); check("R8 FF ignored in erase", rd_status, 1);
    wr(0, 16'h00D0);
    wr(0, 16'h0040); wr(0, 16'h5555);
    check_counts("R8 gated");
    wr(0, 16'hCCB0); e_susp++;
    check_counts("R8 suspend");
    seq_susp = 1'b1; seq_busy = 1'b0;
    repeat (2) @(negedge clk);
    wr(0, 16'h0020); wr(0, 16'h00D0); e_res++;
    check_counts("R9 erase setup ignored");
    seq_susp = 1'b0; seq_busy = 1'b1;
    repeat (2) @(negedge clk);
    wr(0, 16'h00B0); e_susp++;
    seq_susp = 1'b1; seq_busy = 1'b0;
    repeat (2) @(negedge clk);
    wr(0, 16'h0040); wr(0, 16'h1234);
    check_counts("R9 program setup ignored");
    wr(0, 16'h00FF); check("R9 array read in suspend", rd_status, 0);
    wr(0, 16'h0070); check("R9 status read in suspend", rd_status, 1);
    wr(0, 16'h00FF);
    wr(0, 16'h00D0); e_res++;
    check_counts("R9 resume");
    check("R9 resume status mode", rd_status, 1);
    seq_susp = 1'b0;
    seq_run();
    wr(0, 16'h00FF); check("R8 idle after erase", rd_status, 0);
    check("R11 no overlap or stretch", n_overlap, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_modes();
    t_program();
    t_abort();
    t_prog_gate();
    t_erase();
    t_erase_bad();
    t_suspend();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule